// File: doc/BRIEF.md
# Region Write Guard with Sticky Commit

This block decides, for every bus write aimed at one of several protected register regions, whether that write may reach the region's register bank. Each region has a lock flag. While a region's lock is set, the block withholds that region's write enable, so the write is dropped quietly: no error is raised and the region keeps its contents. The write strobe and the index of the target region come in, and one write enable per region goes out to the banks downstream.

Each lock flag is guarded by its own commit flag. Software can set a commit flag but can never clear it. Once a commit flag is set, the matching lock flag is frozen at whatever value it held, and stays that way until the next system reset. Freezing a lock at 0 is allowed, and it leaves that region writable for good. The lock flags and the commit flags are each gathered into one 32-bit configuration word. Both words are reachable through a simple write-strobe/address/data port with a combinational read-back path.

Top module: `region_write_guard`

## Requirements
- R1: After reset every lock and commit flag is 0, both configuration words read back as 0, and every region accepts writes.
- R2: A write to the lock word at byte offset 0x90 copies data bit 1+i into the lock flag of region i (regions 0 to 4) for every region whose commit flag is clear. A lock value of 1 means locked. The new value reads back from offset 0x90 in bits 5:1 from the next cycle.
- R3: In both configuration words, bit 0 and bits 31:6 always read as 0, whatever was written to them.
- R4: The enable for region i is 1 only when the target write strobe is high, the target index equals i, and the lock flag of region i is 0. At most one enable is high at a time.
- R5: A write to the commit word at byte offset 0x94 sets the commit flag of region i when data bit 1+i is 1. A 0 bit leaves that flag unchanged. Several regions can be committed by one write. Commit flags read back from offset 0x94 in bits 5:1.
- R6: Once set, a commit flag stays set until reset, no matter what later writes carry.
- R7: A region whose commit flag is set keeps its lock flag unchanged through lock-word writes. This holds whether the lock was frozen at 1 or at 0.
- R8: Region enables are judged on the lock value held before the current cycle's configuration write. A region write issued in the same cycle as the lock write that locks it still goes through, and the lock takes effect from the next cycle.
- R9: A configuration write to any offset other than 0x90 or 0x94 changes no flag. Such offsets read as 0. A target index of 5 or higher enables no region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (write and read) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| tgt_we | input | 1 | Write strobe aimed at a protected region |
| tgt_region | input | 3 | Index of the region targeted by tgt_we |
| region_we | output | 5 | Per-region write enable to the downstream banks |

## Verification
A lock-word write and a region write can land in the same cycle. So can a lock-word write and a commit flag that was set just before it. The bench drives a lock-setting write together with a target write to the same region, and expects that region's enable to stay high in that cycle and drop in the next. It also writes to the lock word right after committing, and expects the committed bits to hold. A behavioural model holds its own lock and commit bits and is updated only after each clock edge. The enables and the read data are compared against it on every cycle.

// File: rtl/wg_pkg.sv
// Package: shared widths and helpers for the region write guard.
// Assumes a 32-bit configuration data path.
package wg_pkg;
    localparam int unsigned CFG_DATA_W = 32;

    // Width of an index able to name n regions (at least one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/wg_flag_bank.sv
// Module: wg_flag_bank
// Holds one lock flag and one sticky commit flag per region.
// A lock flag follows lock-word writes only while its commit flag is clear.
// A commit flag is set by a 1 written to the commit word and is cleared only by reset.
// Assumes the field for region i sits at data bit FIELD_LSB+i in both words.
module wg_flag_bank #(
    parameter int unsigned NUM_REGIONS = 5,
    parameter int unsigned FIELD_LSB   = 1,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned LOCK_OFS    = 'h90,
    parameter int unsigned COMMIT_OFS  = 'h94
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [NUM_REGIONS-1:0] cfg_field,
    output logic [NUM_REGIONS-1:0] lock_q,
    output logic [NUM_REGIONS-1:0] commit_q
);
    logic lock_hit;
    logic commit_hit;

    // Decode which configuration word is being written this cycle.
    always_comb begin
        lock_hit   = cfg_we && (cfg_addr == ADDR_W'(LOCK_OFS));
        commit_hit = cfg_we && (cfg_addr == ADDR_W'(COMMIT_OFS));
    end

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        // Lock flag: loads from the lock word unless its commit flag (the value before this edge) is set.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_q[i] <= 1'b0;
            else if (lock_hit && !commit_q[i])
                lock_q[i] <= cfg_field[i];
        end

        // Commit flag: set-only, cleared by reset alone.
        always_ff @(posedge clk) begin
            if (!rst_n)
                commit_q[i] <= 1'b0;
            else if (commit_hit && cfg_field[i])
                commit_q[i] <= 1'b1;
        end

        a_r2_lock_update: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_hit && !commit_q[i]) |=> (lock_q[i] == $past(cfg_field[i])));
        a_r5_commit_set: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_hit && cfg_field[i]) |=> commit_q[i]);
        a_r6_commit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            commit_q[i] |=> commit_q[i]);
        a_r7_frozen_lock: assert property (@(posedge clk) disable iff (!rst_n)
            commit_q[i] |=> $stable(lock_q[i]));
    end
endmodule

// File: rtl/wg_read_mux.sv
// Module: wg_read_mux
// Returns the lock or commit word for the addressed offset, and 0 for any other offset.
// Bits outside the region field are always 0.
module wg_read_mux #(
    parameter int unsigned NUM_REGIONS = 5,
    parameter int unsigned FIELD_LSB   = 1,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned LOCK_OFS    = 'h90,
    parameter int unsigned COMMIT_OFS  = 'h94
) (
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [NUM_REGIONS-1:0]        lock_q,
    input  logic [NUM_REGIONS-1:0]        commit_q,
    output logic [wg_pkg::CFG_DATA_W-1:0] cfg_rdata
);
    // Place the selected flag vector into the region field of the read word.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == ADDR_W'(LOCK_OFS))
            cfg_rdata[FIELD_LSB +: NUM_REGIONS] = lock_q;
        else if (cfg_addr == ADDR_W'(COMMIT_OFS))
            cfg_rdata[FIELD_LSB +: NUM_REGIONS] = commit_q;
    end
endmodule

// File: rtl/wg_we_decode.sv
// Module: wg_we_decode
// Turns the target write strobe and region index into one enable per region.
// The enable is suppressed when that region's lock flag is set.
// The lock flag used is the registered one, so a lock written this cycle applies from the next cycle.
module wg_we_decode #(
    parameter int unsigned NUM_REGIONS = 5,
    parameter int unsigned IDX_W       = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tgt_we,
    input  logic [IDX_W-1:0]       tgt_region,
    input  logic [NUM_REGIONS-1:0] lock_q,
    output logic [NUM_REGIONS-1:0] region_we
);
    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_en
        // Enable for region i: addressed, strobed and unlocked.
        always_comb region_we[i] = tgt_we && (tgt_region == IDX_W'(i)) && !lock_q[i];
    end

    a_r4_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_we));
    a_r4_locked_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ((region_we & lock_q) == '0));
    a_r4_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_we |-> (region_we == '0));
endmodule

// File: rtl/region_write_guard.sv
// Module: region_write_guard (top)
// Write protection for NUM_REGIONS register regions, using lock flags that sticky commit flags can freeze.
// Produces per-region write enables, and exposes the lock and commit words on a 32-bit configuration port.
// Assumes a single configuration access per cycle and a synchronous active-low reset.
module region_write_guard #(
    parameter int unsigned NUM_REGIONS = 5,
    parameter int unsigned FIELD_LSB   = 1,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned LOCK_OFS    = 'h90,
    parameter int unsigned COMMIT_OFS  = 'h94,
    localparam int unsigned IDX_W      = wg_pkg::idx_width(NUM_REGIONS),
    localparam int unsigned DATA_W     = wg_pkg::CFG_DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [DATA_W-1:0]      cfg_wdata,
    output logic [DATA_W-1:0]      cfg_rdata,
    input  logic                   tgt_we,
    input  logic [IDX_W-1:0]       tgt_region,
    output logic [NUM_REGIONS-1:0] region_we
);
    logic [NUM_REGIONS-1:0] lock_q;
    logic [NUM_REGIONS-1:0] commit_q;
    logic [NUM_REGIONS-1:0] cfg_field;
    logic                   unused_wdata;

    // Extract the region field from the write data; the other bits are ignored.
    always_comb begin
        cfg_field    = cfg_wdata[FIELD_LSB +: NUM_REGIONS];
        unused_wdata = ^cfg_wdata;
    end

    wg_flag_bank #(
        .NUM_REGIONS(NUM_REGIONS), .FIELD_LSB(FIELD_LSB), .ADDR_W(ADDR_W),
        .LOCK_OFS(LOCK_OFS), .COMMIT_OFS(COMMIT_OFS)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_field(cfg_field), .lock_q(lock_q), .commit_q(commit_q)
    );

    wg_read_mux #(
        .NUM_REGIONS(NUM_REGIONS), .FIELD_LSB(FIELD_LSB), .ADDR_W(ADDR_W),
        .LOCK_OFS(LOCK_OFS), .COMMIT_OFS(COMMIT_OFS)
    ) u_rmux (
        .cfg_addr(cfg_addr), .lock_q(lock_q), .commit_q(commit_q), .cfg_rdata(cfg_rdata)
    );

    wg_we_decode #(
        .NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .tgt_we(tgt_we), .tgt_region(tgt_region),
        .lock_q(lock_q), .region_we(region_we)
    );

    a_r9_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr != ADDR_W'(LOCK_OFS) && cfg_addr != ADDR_W'(COMMIT_OFS))
        |=> ($stable(lock_q) && $stable(commit_q)));
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (lock_q == '0 && commit_q == '0));
endmodule

// File: tb/region_write_guard_test.sv
// Bench: a behavioural reference model (plain bit vectors) compared with the design on every cycle.
module region_write_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tgt_we = 1'b0;
    logic [2:0]  tgt_region = '0;
    logic [4:0]  region_we;

    int vectors = 0;
    int misses  = 0;
    bit [4:0] m_lock   = '0;
    bit [4:0] m_commit = '0;

    always #5 clk = ~clk;

    region_write_guard uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tgt_we(tgt_we),
        .tgt_region(tgt_region), .region_we(region_we)
    );

    // Apply one cycle of stimulus, compare the outputs with the model, then advance the model past the edge.
    task automatic step(input bit we, input bit [7:0] addr, input bit [31:0] wd,
                        input bit twe, input bit [2:0] treg, input string req);
        bit [31:0] exp_rd;
        bit [4:0]  exp_we;
        cfg_we = we; cfg_addr = addr; cfg_wdata = wd; tgt_we = twe; tgt_region = treg;
        #1;
        exp_rd = 32'h0;
        if (addr == 8'h90) exp_rd = {26'h0, m_lock, 1'b0};
        if (addr == 8'h94) exp_rd = {26'h0, m_commit, 1'b0};
        exp_we = (twe && treg < 3'd5 && !m_lock[treg]) ? 5'(1 << treg) : 5'h0;
        vectors++;
        if (cfg_rdata !== exp_rd || region_we !== exp_we) begin
            misses++;
            $display("FAIL %s: rdata=%h we=%b expected rdata=%h we=%b",
                     req, cfg_rdata, region_we, exp_rd, exp_we);
        end
        @(posedge clk);
        if (we && addr == 8'h90)
            for (int i = 0; i < 5; i++) if (!m_commit[i]) m_lock[i] = wd[i+1];
        if (we && addr == 8'h94) m_commit = m_commit | wd[5:1];
        @(negedge clk);
    endtask

    // Hold reset for a few cycles and clear the model.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        m_lock = '0; m_commit = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state, both words zero, every region writable
        step(0, 8'h90, 0, 0, 0, "R1");
        step(0, 8'h94, 0, 0, 0, "R1");
        for (int r = 0; r < 5; r++) step(0, 8'h00, 0, 1, 3'(r), "R1");
        // R2/R3: lock everything, reserved bits written with ones
        step(1, 8'h90, 32'hFFFF_FFFF, 0, 0, "R2");
        step(0, 8'h90, 0, 0, 0, "R3");
        for (int r = 0; r < 5; r++) step(0, 8'h90, 0, 1, 3'(r), "R4");
        step(1, 8'h90, 32'h0000_000B, 0, 0, "R2");
        step(0, 8'h90, 0, 1, 3'd1, "R4");
        step(0, 8'h90, 0, 1, 3'd0, "R4");
        // R8: locking write coincides with a write to the region it locks
        step(1, 8'h90, 32'h0000_003E, 1, 3'd1, "R8");
        step(0, 8'h90, 0, 1, 3'd1, "R8");
        step(1, 8'h90, 32'h0000_0000, 1, 3'd4, "R8");
        step(0, 8'h90, 0, 1, 3'd4, "R8");
        // R9: stray offsets and out-of-range indexes
        step(1, 8'h98, 32'hFFFF_FFFF, 1, 3'd5, "R9");
        step(1, 8'h00, 32'hFFFF_FFFF, 1, 3'd7, "R9");
        step(0, 8'h98, 0, 0, 0, "R9");
        step(0, 8'h90, 0, 0, 0, "R9");
        step(0, 8'h94, 0, 1, 3'd6, "R9");
        // R5: zero write does nothing, then commit regions 0 and 1 while locked
        step(1, 8'h90, 32'h0000_0006, 0, 0, "R2");
        step(1, 8'h94, 32'h0000_0000, 0, 0, "R5");
        step(0, 8'h94, 0, 0, 0, "R5");
        step(1, 8'h94, 32'hFFFF_FFC7, 0, 0, "R5");
        step(0, 8'h94, 0, 0, 0, "R5");
        // R7: frozen at 1, then region 2 frozen at 0
        step(1, 8'h90, 32'h0000_0000, 0, 0, "R7");
        step(0, 8'h90, 0, 1, 3'd0, "R7");
        step(1, 8'h94, 32'h0000_0008, 0, 0, "R5");
        step(1, 8'h90, 32'h0000_003E, 0, 0, "R7");
        step(0, 8'h90, 0, 1, 3'd2, "R7");
        step(0, 8'h90, 0, 1, 3'd3, "R7");
        // R6: commit flags survive zero writes and unrelated writes
        step(1, 8'h94, 32'h0000_0000, 0, 0, "R6");
        step(1, 8'h90, 32'h0000_0000, 0, 0, "R6");
        step(0, 8'h94, 0, 0, 0, "R6");
        step(1, 8'h94, 32'hFFFF_FFFF, 0, 0, "R6");
        step(1, 8'h90, 32'h0000_0008, 0, 0, "R7");
        step(0, 8'h90, 0, 1, 3'd3, "R7");
        step(0, 8'h94, 0, 1, 3'd2, "R6");
        // R1: reset clears commits and locks again
        do_reset();
        step(0, 8'h94, 0, 1, 3'd0, "R1");
        step(0, 8'h90, 0, 1, 3'd4, "R1");
        step(1, 8'h90, 32'h0000_0020, 0, 0, "R2");
        step(0, 8'h90, 0, 1, 3'd4, "R2");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule